// File: doc/BRIEF.md
# Watchdog Timer with Status and Service Registers

This block counts clock cycles and raises a one-cycle reset request when a programmable period has elapsed without service. Software services the timer through an 8-bit register bus by writing a two-byte key to the service register. The first byte is 0x55 and the second is 0xAA. A completed key restarts the count from zero.

A status register holds an enable bit and a timeout flag. The enable bit can be changed only when the debug-mode input is high. Clearing it stops the reset request, but the counter keeps running. The timeout flag records that the last watchdog expiry produced a reset request. It survives every reset except power-on reset, and software clears it by writing zero to the service register.

The key sequence is tracked by a two-state machine.
- IDLE: no key byte is pending.
- ARMED: 0x55 has been seen.

It has these transitions.
- arm (IDLE to ARMED): 0x55 is written.
- complete (ARMED to IDLE): 0xAA is written, and the counter restarts.
- rearm (ARMED to ARMED): 0x55 is written again.
- cancel (ARMED to IDLE): any other value is written.
- flush (any state to IDLE): a system reset or a watchdog reset request.

Top module: `wdog_stat_top`

## Requirements
- R1: With the enable bit at 1, `wd_rst_req` is high for exactly one cycle, starting PERIOD clock edges after the last counter restart. After that pulse the count starts again from zero, so the next pulse follows PERIOD edges later.
- R2: Writing 0x55 and then 0xAA to the service register (address 0x1D) restarts the counter. The edge that accepts 0xAA is counted as count zero.
- R3: After 0x55, a write of any value other than 0xAA or 0x55 cancels the sequence, and a following 0xAA alone has no effect. A second 0x55 keeps the sequence armed, so 0x55, 0x55, 0xAA restarts the counter.
- R4: With the enable bit at 0, no reset request is produced and the timeout flag is not set, but the counter still wraps every PERIOD edges. After the enable bit is set again, the next request comes at the next wrap of that free-running count.
- R5: A reset request sets the timeout flag, which reads as bit 0 of the status register (address 0x1E).
- R6: Writing 0x00 to the service register clears the timeout flag. Any other value written there leaves the flag unchanged.
- R7: Power-on reset (`por_n` low) clears the flag and sets the enable bit to 1. A system reset (`sys_rst` high at a clock edge) sets the enable bit to 1, leaves the flag unchanged, restarts the counter and returns the sequence to IDLE. Bus writes are ignored during that edge.
- R8: A write to the status register loads the enable bit from data bit 1 only when `debug_mode` is 1, and is ignored otherwise. The flag bit cannot be written. Status bits 7 to 2 read as 0.
- R9: `rd_data` follows `bus_addr` combinationally. It shows the status byte at 0x1E and reads 0 at every other address, the service register included.
- R10: When the 0xAA that completes the key is written on the same edge at which the counter would expire, the restart wins. No request is produced, and the next request follows PERIOD edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| sys_rst | input | 1 | Synchronous reset from any other source, active high |
| debug_mode | input | 1 | Allows the enable bit to be written when high |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address for both write and read |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `bus_addr` |
| wd_rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
Two functions can fall on the same edge: the service restart and the expiry of the count. The bench sets up this collision by timing the 0x55 write to land one edge before expiry, so the 0xAA write lands on the expiry edge itself. The result is judged at the ports. No request may appear after that edge, the flag must stay clear, and the next request must arrive exactly PERIOD edges after the 0xAA write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [0:0] {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_t;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/wdog_unlock_fsm.sv
module wdog_unlock_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       flush,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       restart
);
    seq_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            state_q <= SEQ_IDLE;
        else if (flush)
            state_q <= SEQ_IDLE;
        else
            state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        restart = 1'b0;
        if (svc_wr) begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (svc_data == KEY_FIRST)
                        state_d = SEQ_ARMED;
                end
                SEQ_ARMED: begin
                    if (svc_data == KEY_SECOND) begin
                        restart = 1'b1;
                        state_d = SEQ_IDLE;
                    end else if (svc_data == KEY_FIRST) begin
                        state_d = SEQ_ARMED;
                    end else begin
                        state_d = SEQ_IDLE;
                    end
                end
                default: state_d = SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int PERIOD = 1024
) (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic restart,
    input  logic en,
    output logic fire
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = (cnt_q == LAST);
    // the counter wraps regardless of enable; only the request is gated
    assign fire = wrap && en && !restart && !sys_rst;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            cnt_q <= '0;
        else if (sys_rst || restart || wrap)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
    input  logic clk,
    input  logic por_n,
    input  logic sys_rst,
    input  logic debug_mode,
    input  logic stat_wr,
    input  logic en_bit,
    input  logic flag_clr,
    input  logic fire,
    output logic en_q,
    output logic flag_q
);
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            en_q <= 1'b1;
        else if (sys_rst || fire)
            en_q <= 1'b1;
        else if (stat_wr && debug_mode)
            en_q <= en_bit;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            flag_q <= 1'b0;
        else if (fire)
            flag_q <= 1'b1;
        else if (flag_clr)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/wdog_stat_top.sv
module wdog_stat_top #(
    parameter int              PERIOD    = 1024,
    parameter int              ADDR_W    = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(5'h1E),
    parameter logic [ADDR_W-1:0] SVC_ADDR  = ADDR_W'(5'h1D)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              sys_rst,
    input  logic              debug_mode,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic              wd_rst_req
);
    logic stat_wr, svc_wr, svc_restart, fire, wd_en, wd_flag;

    assign stat_wr = bus_we && !sys_rst && (bus_addr == STAT_ADDR);
    assign svc_wr  = bus_we && !sys_rst && (bus_addr == SVC_ADDR);

    wdog_unlock_fsm u_fsm (
        .clk      (clk),
        .por_n    (por_n),
        .flush    (sys_rst || fire),
        .svc_wr   (svc_wr),
        .svc_data (bus_wdata),
        .restart  (svc_restart)
    );

    wdog_counter #(.PERIOD(PERIOD)) u_cnt (
        .clk     (clk),
        .por_n   (por_n),
        .sys_rst (sys_rst),
        .restart (svc_restart),
        .en      (wd_en),
        .fire    (fire)
    );

    wdog_status u_stat (
        .clk        (clk),
        .por_n      (por_n),
        .sys_rst    (sys_rst),
        .debug_mode (debug_mode),
        .stat_wr    (stat_wr),
        .en_bit     (bus_wdata[1]),
        .flag_clr   (svc_wr && (bus_wdata == 8'h00)),
        .fire       (fire),
        .en_q       (wd_en),
        .flag_q     (wd_flag)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            wd_rst_req <= 1'b0;
        else
            wd_rst_req <= fire;
    end

    always_comb begin
        if (bus_addr == STAT_ADDR)
            rd_data = {6'b000000, wd_en, wd_flag};
        else
            rd_data = 8'h00;
    end
endmodule

// File: rtl/wdog_stat_chk.sv
module wdog_stat_chk (
    input logic clk,
    input logic por_n,
    input logic sys_rst,
    input logic wd_rst_req,
    input logic en,
    input logic flag,
    input logic restart
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst_req |=> !wd_rst_req);

    a_r5_flag_with_req: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst_req |-> flag);

    a_r7_sysrst_sets_en: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> en);

    a_r7_sysrst_keeps_flag: assert property (@(posedge clk) disable iff (!por_n)
        sys_rst |=> $stable(flag));

    a_r10_restart_wins: assert property (@(posedge clk) disable iff (!por_n)
        restart |=> !wd_rst_req);

    a_r4_disabled_silent: assert property (@(posedge clk) disable iff (!por_n)
        !en |=> !wd_rst_req);
endmodule

bind wdog_stat_top wdog_stat_chk u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .sys_rst    (sys_rst),
    .wd_rst_req (wd_rst_req),
    .en         (wd_en),
    .flag       (wd_flag),
    .restart    (svc_restart)
);

// File: tb/tb_wdog_stat_top.sv
module tb_wdog_stat_top;
    localparam int P = 40;
    localparam logic [4:0] ST = 5'h1E;
    localparam logic [4:0] SV = 5'h1D;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       sys_rst = 1'b0;
    logic       debug_mode = 1'b1;
    logic       bus_we = 1'b0;
    logic [4:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic       wd_rst_req;

    int compared = 0;
    int mismatched = 0;
    int unsigned cyc = 0;
    int unsigned base = 0;
    int unsigned t = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wdog_stat_top #(.PERIOD(P)) dut (
        .clk(clk), .por_n(por_n), .sys_rst(sys_rst), .debug_mode(debug_mode),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rd_data(rd_data), .wd_rst_req(wd_rst_req)
    );

    // vector: debug, write enable, write addr, write data, read addr, expected read
    typedef struct packed {
        logic       dbg;
        logic       we;
        logic [4:0] wa;
        logic [7:0] wd;
        logic [4:0] ra;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b1, 5'h1E, 8'hFF, 5'h1E, 8'h02},
        '{1'b1, 1'b1, 5'h1E, 8'h00, 5'h1E, 8'h00},
        '{1'b1, 1'b1, 5'h1E, 8'hFE, 5'h1E, 8'h02},
        '{1'b1, 1'b1, 5'h1E, 8'h01, 5'h1E, 8'h00},
        '{1'b0, 1'b1, 5'h1E, 8'h02, 5'h1E, 8'h00},
        '{1'b1, 1'b1, 5'h1E, 8'h02, 5'h1E, 8'h02},
        '{1'b1, 1'b0, 5'h1D, 8'h00, 5'h1D, 8'h00},
        '{1'b1, 1'b0, 5'h00, 8'h00, 5'h05, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [4:0] a, input logic [7:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic wait_until(input int unsigned target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic req_at(input int unsigned target, input logic exp, input string tag);
        wait_until(target);
        chk(tag, {7'b0, wd_rst_req}, {7'b0, exp});
    endtask

    task automatic do_sysrst();
        @(negedge clk);
        sys_rst = 1'b1;
        @(negedge clk);
        sys_rst = 1'b0;
        base = cyc;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog expired actual 1 expected 0");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        rd_chk(ST, 8'h02, "R7 power-on status");
        chk("R1 no request in reset", {7'b0, wd_rst_req}, 8'h00);
        por_n = 1'b1;

        // register vectors: R8 write rules, R9 read decode
        for (int i = 0; i < 8; i++) begin
            debug_mode = VECS[i].dbg;
            if (VECS[i].we) wr(VECS[i].wa, VECS[i].wd);
            rd_chk(VECS[i].ra, VECS[i].exp, $sformatf("R8/R9 vector %0d", i));
        end
        debug_mode = 1'b1;

        // R1 period and single pulse, then repeat after watchdog restart
        do_sysrst();
        req_at(base + P - 1, 1'b0, "R1 before expiry");
        req_at(base + P, 1'b1, "R1 pulse");
        rd_chk(ST, 8'h03, "R5 flag set by request");
        req_at(base + P + 1, 1'b0, "R1 pulse single cycle");
        req_at(base + 2 * P - 1, 1'b0, "R1 before second expiry");
        req_at(base + 2 * P, 1'b1, "R1 second pulse");

        // R7 system reset keeps flag and sets enable
        @(negedge clk);
        wr(ST, 8'h00);
        rd_chk(ST, 8'h01, "R8 enable cleared");
        do_sysrst();
        rd_chk(ST, 8'h03, "R7 sys reset keeps flag, sets enable");

        // R6 flag clear
        wr(SV, 8'h12);
        rd_chk(ST, 8'h03, "R6 nonzero write keeps flag");
        wr(SV, 8'h00);
        rd_chk(ST, 8'h02, "R6 zero write clears flag");

        // R2 service restart
        do_sysrst();
        wait_until(base + 10);
        wr(SV, 8'h55);
        wr(SV, 8'hAA);
        t = cyc;
        req_at(base + P, 1'b0, "R2 old expiry suppressed");
        req_at(t + P - 1, 1'b0, "R2 before new expiry");
        req_at(t + P, 1'b1, "R2 pulse after restart");

        // R3 cancelled sequence
        do_sysrst();
        wait_until(base + 10);
        wr(SV, 8'h55);
        wr(SV, 8'h12);
        wr(SV, 8'hAA);
        req_at(base + P - 1, 1'b0, "R3 cancel before expiry");
        req_at(base + P, 1'b1, "R3 cancelled key does not restart");

        // R3 rearm with double 0x55
        do_sysrst();
        wait_until(base + 5);
        wr(SV, 8'h55);
        wr(SV, 8'h55);
        wr(SV, 8'hAA);
        t = cyc;
        req_at(base + P, 1'b0, "R3 rearmed key restarts");
        req_at(t + P, 1'b1, "R3 pulse after rearmed restart");

        // R10 service on the expiry edge
        wr(SV, 8'h00);
        do_sysrst();
        wait_until(base + P - 2);
        wr(SV, 8'h55);
        wr(SV, 8'hAA);
        t = cyc;
        chk("R10 collision edge index", 8'(t - base), 8'(P));
        chk("R10 no request on collision", {7'b0, wd_rst_req}, 8'h00);
        rd_chk(ST, 8'h02, "R10 flag stays clear");
        req_at(t + P, 1'b1, "R10 pulse one period after service");

        // R4 disabled: counter keeps running
        @(negedge clk);
        wr(SV, 8'h00);
        do_sysrst();
        wr(ST, 8'h00);
        req_at(base + P, 1'b0, "R4 no request while disabled");
        wait_until(base + P + 1);
        rd_chk(ST, 8'h00, "R4 flag not set while disabled");
        wait_until(base + P + 5);
        wr(ST, 8'h02);
        req_at(base + 2 * P - 1, 1'b0, "R4 before free-running wrap");
        req_at(base + 2 * P, 1'b1, "R4 request at free-running wrap");

        // R8 write ignored without debug mode
        @(negedge clk);
        debug_mode = 1'b0;
        wr(ST, 8'h00);
        rd_chk(ST, 8'h03, "R8 status write ignored without debug");
        debug_mode = 1'b1;

        // R7 power-on reset clears flag and sets enable
        wr(ST, 8'h00);
        rd_chk(ST, 8'h01, "R8 enable cleared before power-on");
        por_n = 1'b0;
        #1;
        rd_chk(ST, 8'h02, "R7 power-on clears flag");
        @(negedge clk);
        por_n = 1'b1;

        summary();
    end
endmodule